// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a parallel NOR flash. After software or a sequencer has issued the last write cycle of a program or erase command, it pulses `startPulse`. With that pulse it supplies the polling method, whether the operation is an erase, the byte address to poll, and bit 7 of the byte being programmed. The controller then reads that address again and again through a simple request/valid read port. It decides from each returned status byte whether the embedded operation has finished. Once it has, it issues one more read to fetch settled data.

Two completion tests are available. In status-bit mode, bit 7 of the returned byte must equal the target bit. For a program the target is bit 7 of the programmed byte; for an erase it is a one. In toggle mode, bit 6 flips on every read while the operation runs, so the operation is finished when two successive reads return the same bit 6.

In both modes, the lower bits on the read that first shows completion cannot be trusted. The byte from the extra confirming read is therefore the one reported. If completion never shows within a parameterised number of polling reads, the controller gives up and flags a timeout. For an erase, the caller must supply an address inside a sector that is being erased and is not protected. The caller must also start polling only after the final write pulse of the command: the fourth for a program, the sixth for an erase.

Top module: `flashDonePoller`

## Requirements
- R1: A `startPulse` seen while `busy` is low is accepted, and `busy` is high from the next cycle. A `startPulse` seen while `busy` is high is ignored: the address, the mode and the read count of the running operation do not change.
- R2: `rdReq` is a one-cycle pulse. No new `rdReq` is raised until the previous read has returned its `rdValid`. `rdAddr` holds the accepted address for the whole operation. The first `rdReq` comes one cycle after the accepting edge, and each later one comes one cycle after the `rdValid` of the previous polling read.
- R3: When `startMode` = 0 and `startErase` = 0, a polling read is complete when its bit 7 equals `startExpect7`.
- R4: When `startMode` = 0 and `startErase` = 1, a polling read is complete when its bit 7 is 1, whatever `startExpect7` is.
- R5: When `startMode` = 1, a polling read is complete when its bit 6 equals bit 6 of the previous polling read of the same operation. The first polling read never completes, and `startErase` has no effect in this mode.
- R6: After a complete polling read, exactly one confirming read is issued to the same address. Its byte is reported on `doneData`, with `timeoutErr` = 0.
- R7: `donePulse` is high for exactly one cycle: the cycle after the `rdValid` of the final read. `busy` is low in that cycle.
- R8: If `MAX_READS` polling reads all fail to complete, no confirming read is made. `donePulse` then comes with `timeoutErr` = 1, and `doneData` equals the last polling byte. `timeoutErr` holds until the next accepted start.
- R9: `rdValid` arriving while no read is outstanding is ignored: it causes no `donePulse`, no `rdReq` and no change of `busy`.
- R10: After reset, `busy`, `rdReq`, `donePulse` and `timeoutErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to begin polling |
| startMode | input | 1 | 0 = status-bit (bit 7) polling, 1 = bit 6 toggle polling |
| startErase | input | 1 | 1 = operation is an erase (status-bit mode only) |
| startAddr | input | AW | Byte address to poll |
| startExpect7 | input | 1 | Bit 7 of the byte being programmed |
| rdReq | output | 1 | Read request pulse to the flash bus interface |
| rdAddr | output | AW | Address for the read |
| rdValid | input | 1 | Read data valid, one cycle |
| rdData | input | 8 | Read data |
| busy | output | 1 | An operation is being polled |
| donePulse | output | 1 | One-cycle completion strobe |
| doneData | output | 8 | Final byte, valid with `donePulse` |
| timeoutErr | output | 1 | Polling gave up after `MAX_READS` reads |

## Verification
`busy` is due one cycle after the accepting edge. Each `rdReq` is due one cycle after the previous polling `rdValid`, and `donePulse` exactly one cycle after the final `rdValid`. The bench's flash model answers every request two cycles later. A monitor stamps each `rdValid` and each `donePulse` with a cycle number at the falling edge, and the checks compare those stamps rather than waiting a loose number of cycles. The read count for each scenario is computed from the scripted status bytes and the completion rule, and is compared with the number of requests the model served.

// File: rtl/flashDonePollerPkg.sv
package flashDonePollerPkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_POLL_REQ  = 3'd1,
    ST_POLL_WAIT = 3'd2,
    ST_CONF_REQ  = 3'd3,
    ST_CONF_WAIT = 3'd4
  } pollState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;    // capture start parameters, clear history
    logic sample;  // a polling byte arrived
    logic finOk;   // confirming byte arrived
    logic finTo;   // polling limit reached without completion
  } pollStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic hit;      // current byte shows completion
    logic atLimit;  // current byte is the last allowed polling read
  } pollStatus_t;

endpackage

// File: rtl/flashDonePollerCtrl.sv
module flashDonePollerCtrl
  import flashDonePollerPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        rdValid,
  input  pollStatus_t status,
  output pollStrobe_t strobe,
  output logic        rdReq,
  output logic        busy
);

  pollState_t stateQ, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    stateNxt = stateQ;
    strobe   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.load = 1'b1;
          stateNxt    = ST_POLL_REQ;
        end
      end
      ST_POLL_REQ:  stateNxt = ST_POLL_WAIT;
      ST_POLL_WAIT: begin
        if (rdValid) begin
          strobe.sample = 1'b1;
          if (status.hit) begin
            stateNxt = ST_CONF_REQ;
          end else if (status.atLimit) begin
            strobe.finTo = 1'b1;
            stateNxt     = ST_IDLE;
          end else begin
            stateNxt = ST_POLL_REQ;
          end
        end
      end
      ST_CONF_REQ:  stateNxt = ST_CONF_WAIT;
      ST_CONF_WAIT: begin
        if (rdValid) begin
          strobe.finOk = 1'b1;
          stateNxt     = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign rdReq = (stateQ == ST_POLL_REQ) || (stateQ == ST_CONF_REQ);
  assign busy  = (stateQ != ST_IDLE);

endmodule

// File: rtl/flashDonePollerDp.sv
module flashDonePollerDp
  import flashDonePollerPkg::*;
#(
  parameter int AW        = 20,
  parameter int MAX_READS = 1024
) (
  input  logic          clk,
  input  logic          rstN,
  input  pollStrobe_t   strobe,
  input  logic          startMode,
  input  logic          startErase,
  input  logic [AW-1:0] startAddr,
  input  logic          startExpect7,
  input  logic [7:0]    rdData,
  output pollStatus_t   status,
  output logic [AW-1:0] rdAddr,
  output logic          donePulse,
  output logic [7:0]    doneData,
  output logic          timeoutErr
);

  localparam int CW = $clog2(MAX_READS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(MAX_READS - 1);

  logic [AW-1:0] addrQ;
  logic          modeQ, eraseQ, expBitQ;
  logic          prevBit6Q, havePrevQ;
  logic [CW-1:0] cntQ;
  logic [7:0]    dataQ;
  logic          doneQ, errQ;

  // completion judgement for the byte on rdData
  logic statusHit, toggleHit, targetBit;
  assign targetBit = eraseQ ? 1'b1 : expBitQ;
  assign statusHit = (rdData[7] == targetBit);
  assign toggleHit = havePrevQ && (rdData[6] == prevBit6Q);

  generate
    if (MAX_READS > 1) begin : g_limit
      assign status.atLimit = (cntQ == LAST_IDX);
    end else begin : g_single
      assign status.atLimit = 1'b1;
    end
  endgenerate

  assign status.hit = modeQ ? toggleHit : statusHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      modeQ     <= 1'b0;
      eraseQ    <= 1'b0;
      expBitQ   <= 1'b0;
      prevBit6Q <= 1'b0;
      havePrevQ <= 1'b0;
      cntQ      <= '0;
      dataQ     <= '0;
      doneQ     <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      doneQ <= strobe.finOk | strobe.finTo;
      if (strobe.load) begin
        addrQ     <= startAddr;
        modeQ     <= startMode;
        eraseQ    <= startErase;
        expBitQ   <= startExpect7;
        havePrevQ <= 1'b0;
        cntQ      <= '0;
        errQ      <= 1'b0;
      end
      if (strobe.sample) begin
        prevBit6Q <= rdData[6];
        havePrevQ <= 1'b1;
        cntQ      <= cntQ + 1'b1;
      end
      if (strobe.finOk) begin
        dataQ <= rdData;
        errQ  <= 1'b0;
      end
      if (strobe.finTo) begin
        dataQ <= rdData;
        errQ  <= 1'b1;
      end
    end
  end

  assign rdAddr     = addrQ;
  assign donePulse  = doneQ;
  assign doneData   = dataQ;
  assign timeoutErr = errQ;

endmodule

// File: rtl/flashDonePoller.sv
module flashDonePoller
  import flashDonePollerPkg::*;
#(
  parameter int AW        = 20,
  parameter int MAX_READS = 1024
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic          startMode,
  input  logic          startErase,
  input  logic [AW-1:0] startAddr,
  input  logic          startExpect7,
  output logic          rdReq,
  output logic [AW-1:0] rdAddr,
  input  logic          rdValid,
  input  logic [7:0]    rdData,
  output logic          busy,
  output logic          donePulse,
  output logic [7:0]    doneData,
  output logic          timeoutErr
);

  pollStrobe_t strobe;
  pollStatus_t status;

  flashDonePollerCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .rdValid    (rdValid),
    .status     (status),
    .strobe     (strobe),
    .rdReq      (rdReq),
    .busy       (busy)
  );

  flashDonePollerDp #(
    .AW        (AW),
    .MAX_READS (MAX_READS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .startMode    (startMode),
    .startErase   (startErase),
    .startAddr    (startAddr),
    .startExpect7 (startExpect7),
    .rdData       (rdData),
    .status       (status),
    .rdAddr       (rdAddr),
    .donePulse    (donePulse),
    .doneData     (doneData),
    .timeoutErr   (timeoutErr)
  );

endmodule

// File: rtl/flashDonePollerChk.sv
module flashDonePollerChk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rstN,
  input logic          startPulse,
  input logic          busy,
  input logic          rdReq,
  input logic          rdValid,
  input logic [AW-1:0] rdAddr,
  input logic          donePulse,
  input logic          timeoutErr
);

  logic pendingQ;
  always_ff @(posedge clk) begin
    if (!rstN)        pendingQ <= 1'b0;
    else if (rdReq)   pendingQ <= 1'b1;
    else if (rdValid) pendingQ <= 1'b0;
  end

  a_r1_accept_start: assert property (@(posedge clk) disable iff (!rstN)
    startPulse && !busy |=> busy);

  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !pendingQ);

  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> rdAddr == $past(rdAddr));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy);

  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> donePulse);

  a_r9_no_req_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdReq);

endmodule

bind flashDonePoller flashDonePollerChk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .busy       (busy),
  .rdReq      (rdReq),
  .rdValid    (rdValid),
  .rdAddr     (rdAddr),
  .donePulse  (donePulse),
  .timeoutErr (timeoutErr)
);

// File: tb/flashDonePoller_bench.sv
`timescale 1ns/1ps
module flashDonePoller_bench;

  localparam int AW = 20;
  localparam int MAX_READS = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic          startMode = 1'b0;
  logic          startErase = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic          startExpect7 = 1'b0;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic          rdValid = 1'b0;
  logic [7:0]    rdData = '0;
  logic          busy, donePulse, timeoutErr;
  logic [7:0]    doneData;

  always #4 clk = ~clk;  // 125 MHz

  flashDonePoller #(.AW(AW), .MAX_READS(MAX_READS)) u_flashDonePoller (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startMode(startMode),
    .startErase(startErase), .startAddr(startAddr), .startExpect7(startExpect7),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .busy(busy), .donePulse(donePulse), .doneData(doneData), .timeoutErr(timeoutErr)
  );

  int checks = 0;
  int fails = 0;

  // scripted flash model, two-cycle read latency
  logic [7:0]    script [16];
  int            base = 0;
  logic [AW-1:0] expAddr = '0;
  int            idx = 0;
  int            pendLeft = 0;
  int            protoErrs = 0;
  int            strayReq = 0;
  int            strayDone = 0;
  int            cyc = 0;

  always @(posedge clk) begin
    int k;
    cyc <= cyc + 1;
    rdValid <= 1'b0;
    if (pendLeft > 0) begin
      pendLeft <= pendLeft - 1;
      if (pendLeft == 1) begin
        k = idx - base;
        if (k > 15) k = 15;
        rdValid <= 1'b1;
        rdData  <= script[k];
        idx     <= idx + 1;
      end
    end else if (!rdReq && strayReq != strayDone) begin
      rdValid   <= 1'b1;
      rdData    <= 8'h80;
      strayDone <= strayReq;
    end
    if (rdReq) begin
      if (pendLeft != 0) begin
        protoErrs <= protoErrs + 1;
        $display("FAIL R2: request while read outstanding (pending %0d, expected 0)", pendLeft);
      end
      if (rdAddr != expAddr) begin
        protoErrs <= protoErrs + 1;
        $display("FAIL R2: rdAddr %h, expected %h", rdAddr, expAddr);
      end
      pendLeft <= 2;
    end
  end

  // monitor, sampled at the falling edge
  int         lastValidCyc = 0;
  int         doneCnt = 0;
  int         doneCyc = 0;
  logic [7:0] doneDataSeen = '0;
  logic       doneErrSeen = 1'b0;
  logic       busyAtDone = 1'b0;

  always @(negedge clk) begin
    if (rdValid) lastValidCyc <= cyc;
    if (donePulse) begin
      doneCnt      <= doneCnt + 1;
      doneCyc      <= cyc;
      doneDataSeen <= doneData;
      doneErrSeen  <= timeoutErr;
      busyAtDone   <= busy;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic runOp(input bit mode, input bit erase, input logic [AW-1:0] addr,
                       input bit exp7, input int expReads, input logic [7:0] expData,
                       input bit expErr, input string tag, input bit doubleStart);
    int d0;
    int w;
    base    = idx;
    expAddr = addr;
    d0      = doneCnt;
    @(negedge clk);
    startPulse = 1'b1; startMode = mode; startErase = erase;
    startAddr = addr; startExpect7 = exp7;
    @(negedge clk);
    startPulse = 1'b0;
    check(busy == 1'b1, "R1 busy after start", busy, 1);
    if (doubleStart) begin
      @(negedge clk);
      startPulse = 1'b1; startMode = ~mode; startAddr = addr ^ 20'h55555;
      @(negedge clk);
      startPulse = 1'b0;
    end
    w = 0;
    while (doneCnt == d0 && w < 300) begin
      @(negedge clk);
      w++;
    end
    repeat (5) @(negedge clk);
    check(doneCnt == d0 + 1, {tag, " R7 one done pulse"}, doneCnt - d0, 1);
    check(doneCyc == lastValidCyc + 1, {tag, " R7 done one cycle after final rdValid"},
          doneCyc - lastValidCyc, 1);
    check(busyAtDone == 1'b0, {tag, " R7 busy low with done"}, busyAtDone, 0);
    check(idx - base == expReads, {tag, " read count"}, idx - base, expReads);
    check(doneDataSeen == expData, {tag, " R6 final data"}, doneDataSeen, expData);
    check(doneErrSeen == expErr, {tag, " R8 error flag"}, doneErrSeen, expErr);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(busy == 0 && rdReq == 0 && donePulse == 0 && timeoutErr == 0,
          "R10 reset outputs", {busy, rdReq, donePulse, timeoutErr}, 0);
  endtask

  task automatic testProgramLow();  // R3, R6: expected bit 7 = 0
    script[0] = 8'hA5; script[1] = 8'hC3; script[2] = 8'h4F; script[3] = 8'h5A;
    runOp(1'b0, 1'b0, 20'h12345, 1'b0, 4, 8'h5A, 1'b0, "R3 prog0", 1'b0);
  endtask

  task automatic testProgramHigh();  // R3: expected bit 7 = 1
    script[0] = 8'h31; script[1] = 8'h80; script[2] = 8'hB1;
    runOp(1'b0, 1'b0, 20'h00F0F, 1'b1, 3, 8'hB1, 1'b0, "R3 prog1", 1'b0);
  endtask

  task automatic testErase();  // R4: target 1 regardless of startExpect7 = 0
    script[0] = 8'h00; script[1] = 8'h7F; script[2] = 8'h80; script[3] = 8'hFF;
    runOp(1'b0, 1'b1, 20'h40000, 1'b0, 4, 8'hFF, 1'b0, "R4 erase", 1'b0);
  endtask

  task automatic testToggle(input bit doubleStart);  // R5, R1 when doubleStart
    script[0] = 8'h40; script[1] = 8'h00; script[2] = 8'h40;
    script[3] = 8'h40; script[4] = 8'h9C;
    runOp(1'b1, 1'b0, 20'hABCDE, 1'b0, 5, 8'h9C, 1'b0,
          doubleStart ? "R1 start ignored while busy" : "R5 toggle", doubleStart);
  endtask

  task automatic testToggleQuick();  // R5: second read may complete, erase flag ignored
    script[0] = 8'h80; script[1] = 8'h00; script[2] = 8'h37;
    runOp(1'b1, 1'b1, 20'h00007, 1'b1, 3, 8'h37, 1'b0, "R5 toggle quick", 1'b0);
  endtask

  task automatic testTimeout();  // R8
    for (int i = 0; i < 16; i++) script[i] = 8'h81 + 8'(i);
    runOp(1'b0, 1'b0, 20'h0BEEF, 1'b0, MAX_READS, 8'h86, 1'b1, "R8 timeout", 1'b0);
    check(timeoutErr == 1'b1, "R8 error held after done", timeoutErr, 1);
  endtask

  task automatic testStray();  // R9
    int d0;
    d0 = doneCnt;
    strayReq++;
    repeat (6) begin
      @(negedge clk);
      if (busy || rdReq) begin
        check(1'b0, "R9 stray rdValid woke controller", {busy, rdReq}, 0);
      end
    end
    check(doneCnt == d0, "R9 stray rdValid gave no done", doneCnt - d0, 0);
    check(busy == 1'b0, "R9 busy after stray rdValid", busy, 0);
  endtask

  initial begin
    bit timedOut;
    timedOut = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    fork
      begin
        testReset();
        testProgramLow();
        testProgramHigh();
        testErase();
        testToggle(1'b0);
        testToggleQuick();
        testTimeout();
        testStray();
        testProgramHigh();  // error flag clears on the next operation
        testToggle(1'b1);
      end
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
    end
    check(protoErrs == 0, "R2 read protocol errors", protoErrs, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule